// File: doc/BRIEF.md
# Shadow Stack Token Busy-Clear Unit

This unit executes a single privileged instruction that releases a supervisor shadow stack. The target stack is marked in memory by a 64-bit token, and bit 0 of that token is the busy flag. The instruction names the token by its linear address. When the unit receives a start pulse, it registers the operand address and the mode inputs: the control-enable bit, the supervisor shadow-stack-enable bit, the current privilege level and the lock-prefix indicator. It then checks these inputs for faults in a fixed order.

If no fault is found, the unit locks the memory port and reads the token. It compares the value read against the operand address with bit 0 set. On a match it writes back the bare address, which clears the busy flag, and then releases the lock. A token that does not match is not treated as a fault. It sets the carry flag instead and leaves memory as it was. In both cases the unit clears the other five arithmetic flags and loads zero into the shadow stack pointer register.

A fault leaves flags, pointer and memory untouched. It is reported as a vector code and an error code together with the one-cycle done pulse. A page-fault indication on the memory port during the read or the write aborts the operation.

Top module: `ssbc_unit`

## Requirements
- R1: The unit raises vector 6 with error code 0 and makes no memory request in three cases: the lock-prefix indicator is 1, the control-enable bit is 0, or the supervisor shadow-stack-enable bit is 0.
- R2: The enable and lock checks take priority over privilege. If R1 does not apply and the privilege level is non-zero, the unit raises vector 13 with error code 0 and makes no memory request.
- R3: If the operand address has any of its low three bits set, the unit raises vector 13 with error code 0 and makes no memory request. Every memory access uses an 8-byte-aligned address.
- R4: When the token read equals address|1, the unit writes exactly the address back to the same location, under the lock, and the carry flag ends at 0. A fault-free operation with a matching token takes 6 cycles from the start edge to done. An operation with a mismatching token takes 5 cycles.
- R5: When the token read differs from address|1, the unit makes no write and the carry flag ends at 1.
- R6: flags_o bits are carry[0], zero[1], parity[2], aux-carry[3], overflow[4] and sign[5]. Bits 5 down to 1 are 0 after any fault-free completion.
- R7: ssp_o is 0 after any fault-free completion, whether or not the token matched.
- R8: On any fault, flags_o, ssp_o and memory keep their previous values, and done_o rises together with fault_o. A fault from the checks arrives 2 cycles after the start edge.
- R9: When the page-fault input is set with the acknowledge of the read or of the write, the unit aborts. It reports vector 14 with the supplied fault code, performs no further access and releases the lock.
- R10: done_o is high for exactly one cycle per operation. A start pulse that arrives while an operation is in progress is ignored.
- R11: mem_lock_o is high continuously from the read request until the write is acknowledged or skipped, and then goes low. The lock is held for 3 cycles on a match and 2 cycles on a mismatch when the memory answers at once. A request is held with a stable address until it is acknowledged.
- R12: After reset, done_o and mem_req_o are low, flags_o equals FLAGS_RST and ssp_o equals SSP_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| op_addr_i | input | ADDR_W | Linear address of the token |
| cet_en_i | input | 1 | Control-enable bit |
| sstk_en_i | input | 1 | Supervisor shadow-stack-enable bit |
| cpl_i | input | 2 | Current privilege level |
| lock_pfx_i | input | 1 | Lock prefix present |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_lock_o | output | 1 | Memory lock held |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | ADDR_W | Write data |
| mem_ack_i | input | 1 | Access acknowledge |
| mem_rdata_i | input | ADDR_W | Read data, valid with acknowledge |
| mem_pf_i | input | 1 | Page fault, valid with acknowledge |
| mem_pf_code_i | input | ECODE_W | Page-fault error code |
| done_o | output | 1 | Operation finished, one cycle |
| fault_o | output | 1 | Operation ended in a fault, valid with done |
| fault_vec_o | output | 8 | Fault vector, valid with done and fault |
| fault_err_o | output | ECODE_W | Fault error code, valid with done and fault |
| flags_o | output | 6 | Arithmetic flags register |
| ssp_o | output | ADDR_W | Shadow stack pointer register |

## Verification
The properties assume three things about the memory port. It raises the acknowledge only for a request that is outstanding. It raises the page-fault flag only together with the acknowledge. It never acknowledges in two back-to-back cycles. The bench memory model keeps to these rules: it answers each request once after a chosen delay, drops the acknowledge on the next cycle and injects page faults only on an acknowledge. The mode inputs are driven only around a start pulse, so the registered copy always matches the operation being checked.

// File: rtl/ssbc_pkg.sv
package ssbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOCK_READ,
        ST_COMPARE,
        ST_WRITE,
        ST_UNLOCK,
        ST_DONE,
        ST_FAULT
    } ssbc_state_e;

    typedef enum logic [1:0] {
        FK_NONE,
        FK_UD,
        FK_GP,
        FK_PF
    } fault_kind_e;

    localparam logic [7:0] VEC_UD = 8'd6;
    localparam logic [7:0] VEC_GP = 8'd13;
    localparam logic [7:0] VEC_PF = 8'd14;

    localparam int NFLAGS  = 6;
    localparam int FLAG_CF = 0;
    localparam int FLAG_ZF = 1;
    localparam int FLAG_PF = 2;
    localparam int FLAG_AF = 3;
    localparam int FLAG_OF = 4;
    localparam int FLAG_SF = 5;

    typedef struct packed {
        logic       cet_en;
        logic       sstk_en;
        logic       lock_pfx;
        logic [1:0] cpl;
    } ssbc_ctl_t;

    // Fixed priority: opcode faults, then privilege, then alignment.
    function automatic fault_kind_e classify(ssbc_ctl_t c, logic misaligned);
        if (c.lock_pfx || !c.cet_en || !c.sstk_en) return FK_UD;
        if (c.cpl != 2'd0)                          return FK_GP;
        if (misaligned)                             return FK_GP;
        return FK_NONE;
    endfunction

    function automatic logic [7:0] vec_of(fault_kind_e k);
        case (k)
            FK_UD:   return VEC_UD;
            FK_GP:   return VEC_GP;
            FK_PF:   return VEC_PF;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/ssbc_fault_check.sv
module ssbc_fault_check
    import ssbc_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 8
) (
    input  ssbc_ctl_t          ctl_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output fault_kind_e        kind_o
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    logic misaligned;

    generate
        if (ALIGN_LSB > 0) begin : g_align
            assign misaligned = |addr_i[ALIGN_LSB-1:0];
        end else begin : g_noalign
            assign misaligned = 1'b0;
        end
    endgenerate

    assign kind_o = classify(ctl_i, misaligned);

endmodule

// File: rtl/ssbc_token_gen.sv
module ssbc_token_gen #(
    parameter int ADDR_W   = 64,
    parameter int BUSY_BIT = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] expect_o,
    output logic [ADDR_W-1:0] replace_o,
    output logic              match_o
);
    localparam logic [ADDR_W-1:0] BUSY_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << BUSY_BIT;

    assign expect_o  = addr_i | BUSY_MASK;
    assign replace_o = addr_i;
    assign match_o   = (rdata_i == expect_o);

endmodule

// File: rtl/ssbc_ctrl.sv
module ssbc_ctrl
    import ssbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  fault_kind_e chk_kind_i,
    input  logic        mem_ack_i,
    input  logic        mem_pf_i,
    input  logic        match_i,
    output ssbc_state_e state_o
);
    ssbc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_CHECK;
            ST_CHECK:     state_d = (chk_kind_i != FK_NONE) ? ST_FAULT : ST_LOCK_READ;
            ST_LOCK_READ: if (mem_ack_i) state_d = mem_pf_i ? ST_FAULT : ST_COMPARE;
            ST_COMPARE:   state_d = match_i ? ST_WRITE : ST_UNLOCK;
            ST_WRITE:     if (mem_ack_i) state_d = mem_pf_i ? ST_FAULT : ST_UNLOCK;
            ST_UNLOCK:    state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/ssbc_unit.sv
module ssbc_unit
    import ssbc_pkg::*;
#(
    parameter int                 ADDR_W      = 64,
    parameter int                 ECODE_W     = 16,
    parameter int                 ALIGN_BYTES = 8,
    parameter int                 BUSY_BIT    = 0,
    parameter logic [5:0]         FLAGS_RST   = 6'h3E,
    parameter logic [ADDR_W-1:0]  SSP_RST     = 64'h0000_7FFF_FFFF_F000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  op_addr_i,
    input  logic               cet_en_i,
    input  logic               sstk_en_i,
    input  logic [1:0]         cpl_i,
    input  logic               lock_pfx_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic               mem_lock_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [ADDR_W-1:0]  mem_wdata_o,
    input  logic               mem_ack_i,
    input  logic [ADDR_W-1:0]  mem_rdata_i,
    input  logic               mem_pf_i,
    input  logic [ECODE_W-1:0] mem_pf_code_i,
    output logic               done_o,
    output logic               fault_o,
    output logic [7:0]         fault_vec_o,
    output logic [ECODE_W-1:0] fault_err_o,
    output logic [5:0]         flags_o,
    output logic [ADDR_W-1:0]  ssp_o
);
    ssbc_state_e          state;
    ssbc_ctl_t            ctl_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [ADDR_W-1:0]    rdata_q;
    logic [ADDR_W-1:0]    expect_tok;
    logic [ADDR_W-1:0]    replace_tok;
    logic                 match;
    fault_kind_e          chk_kind;
    logic [NFLAGS-1:0]    flags_q;
    logic [ADDR_W-1:0]    ssp_q;
    logic [7:0]           vec_q;
    logic [ECODE_W-1:0]   err_q;
    logic                 mem_abort;

    ssbc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .chk_kind_i (chk_kind),
        .mem_ack_i  (mem_ack_i),
        .mem_pf_i   (mem_pf_i),
        .match_i    (match),
        .state_o    (state)
    );

    ssbc_fault_check #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_chk (
        .ctl_i  (ctl_q),
        .addr_i (addr_q),
        .kind_o (chk_kind)
    );

    ssbc_token_gen #(.ADDR_W(ADDR_W), .BUSY_BIT(BUSY_BIT)) u_tok (
        .addr_i    (addr_q),
        .rdata_i   (rdata_q),
        .expect_o  (expect_tok),
        .replace_o (replace_tok),
        .match_o   (match)
    );

    assign mem_abort = mem_ack_i && mem_pf_i &&
                       (state == ST_LOCK_READ || state == ST_WRITE);

    // Operand capture and token read-back.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && start_i) begin
                ctl_q  <= '{cet_en: cet_en_i, sstk_en: sstk_en_i,
                           lock_pfx: lock_pfx_i, cpl: cpl_i};
                addr_q <= op_addr_i;
            end
            if (state == ST_LOCK_READ && mem_ack_i && !mem_pf_i)
                rdata_q <= mem_rdata_i;
        end
    end

    // Fault report registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            err_q <= '0;
        end else if (state == ST_CHECK && chk_kind != FK_NONE) begin
            vec_q <= vec_of(chk_kind);
            err_q <= '0;
        end else if (mem_abort) begin
            vec_q <= vec_of(FK_PF);
            err_q <= mem_pf_code_i;
        end
    end

    // Architectural state, written only on the fault-free path.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_RST;
            ssp_q   <= SSP_RST;
        end else if (state == ST_UNLOCK) begin
            flags_q          <= '0;
            flags_q[FLAG_CF] <= !match;
            ssp_q            <= '0;
        end
    end

    assign mem_req_o   = (state == ST_LOCK_READ) || (state == ST_WRITE);
    assign mem_we_o    = (state == ST_WRITE);
    assign mem_lock_o  = (state == ST_LOCK_READ) || (state == ST_COMPARE) ||
                         (state == ST_WRITE);
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = replace_tok;

    assign done_o      = (state == ST_DONE) || (state == ST_FAULT);
    assign fault_o     = (state == ST_FAULT);
    assign fault_vec_o = vec_q;
    assign fault_err_o = err_q;
    assign flags_o     = flags_q;
    assign ssp_o       = ssp_q;

endmodule

// File: rtl/ssbc_unit_chk.sv
module ssbc_unit_chk #(
    parameter int ADDR_W      = 64,
    parameter int ECODE_W     = 16,
    parameter int ALIGN_BYTES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               mem_req_o,
    input logic               mem_we_o,
    input logic               mem_lock_o,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic [ADDR_W-1:0]  mem_wdata_o,
    input logic               mem_ack_i,
    input logic               mem_pf_i,
    input logic               done_o,
    input logic               fault_o,
    input logic [7:0]         fault_vec_o,
    input logic [5:0]         flags_o,
    input logic [ADDR_W-1:0]  ssp_o
);
    localparam int ALIGN_LSB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;
    localparam logic [ALIGN_LSB-1:0] ALIGN_ZERO = '0;

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_access_locked_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> mem_lock_o);

    p_req_held_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    p_write_token_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o |-> mem_wdata_o == mem_addr_o);

    p_aligned_access_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (ALIGN_BYTES <= 1) || (mem_addr_o[ALIGN_LSB-1:0] == ALIGN_ZERO));

    p_fault_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
        done_o && fault_o |-> $stable(flags_o) && $stable(ssp_o));

    p_ssp_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        done_o && !fault_o |-> ssp_o == '0);

    p_flags_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        done_o && !fault_o |-> flags_o[5:1] == 5'd0);

    p_pf_release_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ack_i && mem_pf_i |=> !mem_lock_o && !mem_req_o && done_o && fault_o);

    p_fault_vec_r1: assert property (@(posedge clk) disable iff (rst)
        done_o && fault_o |-> fault_vec_o == 8'd6 || fault_vec_o == 8'd13 || fault_vec_o == 8'd14);

endmodule

bind ssbc_unit ssbc_unit_chk #(.ADDR_W(ADDR_W), .ECODE_W(ECODE_W), .ALIGN_BYTES(ALIGN_BYTES)) u_unit_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_lock_o  (mem_lock_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_pf_i    (mem_pf_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_vec_o (fault_vec_o),
    .flags_o     (flags_o),
    .ssp_o       (ssp_o)
);

// File: tb/ssbc_unit_tb_top.sv
module ssbc_unit_tb_top;
    localparam int          AW        = 64;
    localparam int          EW        = 16;
    localparam logic [5:0]  FLAGS_RST = 6'h3E;
    localparam logic [63:0] SSP_RST   = 64'h0000_7FFF_FFFF_F000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] op_addr_i = '0;
    logic          cet_en_i = 1'b1;
    logic          sstk_en_i = 1'b1;
    logic [1:0]    cpl_i = 2'd0;
    logic          lock_pfx_i = 1'b0;
    logic          mem_req_o, mem_we_o, mem_lock_o;
    logic [AW-1:0] mem_addr_o, mem_wdata_o;
    logic          mem_ack_i = 1'b0;
    logic [AW-1:0] mem_rdata_i = '0;
    logic          mem_pf_i = 1'b0;
    logic [EW-1:0] mem_pf_code_i = '0;
    logic          done_o, fault_o;
    logic [7:0]    fault_vec_o;
    logic [EW-1:0] fault_err_o;
    logic [5:0]    flags_o;
    logic [AW-1:0] ssp_o;

    ssbc_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_addr_i(op_addr_i),
        .cet_en_i(cet_en_i), .sstk_en_i(sstk_en_i), .cpl_i(cpl_i), .lock_pfx_i(lock_pfx_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_lock_o(mem_lock_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .mem_pf_i(mem_pf_i), .mem_pf_code_i(mem_pf_code_i),
        .done_o(done_o), .fault_o(fault_o), .fault_vec_o(fault_vec_o),
        .fault_err_o(fault_err_o), .flags_o(flags_o), .ssp_o(ssp_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Memory model and monitor state.
    logic [63:0] mem [0:7];
    int  lat = 0;
    bit  pf_on_read = 0;
    bit  pf_on_write = 0;
    int  n_reads = 0, n_writes = 0, n_done = 0, lock_rises = 0, lock_cycles = 0;
    int  unlocked_access = 0;
    bit  lock_prev = 0;
    int  wcnt = 0;
    int  cycle = 0;

    // Results of the last operation.
    int          r_lat;
    logic        r_fault;
    logic [7:0]  r_vec;
    logic [15:0] r_err;
    logic [5:0]  r_flags;
    logic [63:0] r_ssp;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor first, then memory responder, at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cycle++;
            if (done_o) n_done++;
            if (mem_lock_o) lock_cycles++;
            if (mem_lock_o && !lock_prev) lock_rises++;
            lock_prev = mem_lock_o;
            if (mem_req_o && !mem_lock_o) unlocked_access++;
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
                mem_pf_i = 1'b0;
                wcnt = 0;
            end else if (mem_req_o) begin
                if (wcnt >= lat) begin
                    mem_ack_i = 1'b1;
                    if (mem_we_o) begin
                        n_writes++;
                        mem_pf_i = pf_on_write;
                        if (!pf_on_write) mem[mem_addr_o[5:3]] = mem_wdata_o;
                    end else begin
                        n_reads++;
                        mem_pf_i = pf_on_read;
                        mem_rdata_i = mem[mem_addr_o[5:3]];
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cycle > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycle, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        start_i = 1'b0;
        lat = 0; pf_on_read = 0; pf_on_write = 0;
        for (int i = 0; i < 8; i++) mem[i] = 64'hA5A5_0000_0000_0000 + 64'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_op(input logic [63:0] a, input logic cet, input logic sstk,
                          input logic [1:0] cpl, input logic lk);
        @(negedge clk);
        n_reads = 0; n_writes = 0; n_done = 0; lock_rises = 0; lock_cycles = 0;
        unlocked_access = 0;
        op_addr_i = a; cet_en_i = cet; sstk_en_i = sstk; cpl_i = cpl; lock_pfx_i = lk;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        r_lat = 1;
        while (!done_o && r_lat < 200) begin
            @(negedge clk);
            r_lat++;
        end
        r_fault = fault_o; r_vec = fault_vec_o; r_err = fault_err_o;
        r_flags = flags_o; r_ssp = ssp_o;
        repeat (3) @(negedge clk);
        chk(n_done == 1, "R10 done pulse count", 64'(n_done), 64'd1);
    endtask

    task automatic expect_fault(input string req, input logic [7:0] vec, input logic [15:0] err,
                                input int lat_exp);
        chk(r_fault == 1'b1, req, 64'(r_fault), 64'd1);
        chk(r_vec == vec, req, 64'(r_vec), 64'(vec));
        chk(r_err == err, req, 64'(r_err), 64'(err));
        if (lat_exp > 0) chk(r_lat == lat_exp, "R8 fault latency", 64'(r_lat), 64'(lat_exp));
        chk(r_flags == FLAGS_RST, "R8 flags kept", 64'(r_flags), 64'(FLAGS_RST));
        chk(r_ssp == SSP_RST, "R8 ssp kept", r_ssp, SSP_RST);
        chk(lock_prev == 1'b0, "R9 lock released", 64'(lock_prev), 64'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(done_o == 1'b0, "R12 done low", 64'(done_o), 64'd0);
        chk(mem_req_o == 1'b0, "R12 no request", 64'(mem_req_o), 64'd0);
        chk(flags_o == FLAGS_RST, "R12 flags reset", 64'(flags_o), 64'(FLAGS_RST));
        chk(ssp_o == SSP_RST, "R12 ssp reset", ssp_o, SSP_RST);
    endtask

    task automatic t_ud();
        do_reset();
        run_op(64'h1008, 1, 1, 0, 1);
        expect_fault("R1 lock prefix", 8'd6, 16'd0, 2);
        chk(n_reads + n_writes == 0, "R1 no access", 64'(n_reads + n_writes), 64'd0);
        run_op(64'h1008, 0, 1, 0, 0);
        expect_fault("R1 control disabled", 8'd6, 16'd0, 2);
        run_op(64'h1008, 1, 0, 0, 0);
        expect_fault("R1 stack disabled", 8'd6, 16'd0, 2);
        chk(n_reads + n_writes == 0, "R1 no access", 64'(n_reads + n_writes), 64'd0);
        chk(mem[1] == 64'hA5A5_0000_0000_0001, "R8 memory kept", mem[1], 64'hA5A5_0000_0000_0001);
    endtask

    task automatic t_priv();
        do_reset();
        run_op(64'h1008, 0, 1, 3, 0);
        expect_fault("R2 enable before privilege", 8'd6, 16'd0, 2);
        run_op(64'h1008, 1, 1, 3, 0);
        expect_fault("R2 privilege", 8'd13, 16'd0, 2);
        chk(n_reads + n_writes == 0, "R2 no access", 64'(n_reads + n_writes), 64'd0);
    endtask

    task automatic t_align();
        do_reset();
        mem[1] = 64'h100D;
        run_op(64'h100C, 1, 1, 0, 0);
        expect_fault("R3 misaligned", 8'd13, 16'd0, 2);
        chk(n_reads + n_writes == 0, "R3 no access", 64'(n_reads + n_writes), 64'd0);
        run_op(64'h1009, 1, 1, 0, 0);
        expect_fault("R3 misaligned bit0", 8'd13, 16'd0, 2);
    endtask

    task automatic t_valid();
        do_reset();
        mem[1] = 64'h1009;
        run_op(64'h1008, 1, 1, 0, 0);
        chk(r_fault == 1'b0, "R4 no fault", 64'(r_fault), 64'd0);
        chk(mem[1] == 64'h1008, "R4 busy cleared", mem[1], 64'h1008);
        chk(n_writes == 1, "R4 one write", 64'(n_writes), 64'd1);
        chk(r_lat == 6, "R4 latency", 64'(r_lat), 64'd6);
        chk(r_flags == 6'h00, "R6 flags all clear", 64'(r_flags), 64'd0);
        chk(r_ssp == 64'd0, "R7 ssp cleared", r_ssp, 64'd0);
        chk(lock_rises == 1, "R11 single lock", 64'(lock_rises), 64'd1);
        chk(lock_cycles == 3, "R11 lock length", 64'(lock_cycles), 64'd3);
        chk(unlocked_access == 0, "R11 locked access", 64'(unlocked_access), 64'd0);
    endtask

    task automatic t_invalid();
        do_reset();
        mem[2] = 64'h1010;
        run_op(64'h1010, 1, 1, 0, 0);
        chk(r_fault == 1'b0, "R5 no fault", 64'(r_fault), 64'd0);
        chk(n_writes == 0, "R5 no write", 64'(n_writes), 64'd0);
        chk(mem[2] == 64'h1010, "R5 memory kept", mem[2], 64'h1010);
        chk(r_flags == 6'h01, "R5 carry set", 64'(r_flags), 64'h01);
        chk(r_ssp == 64'd0, "R7 ssp cleared on mismatch", r_ssp, 64'd0);
        chk(r_lat == 5, "R4 mismatch latency", 64'(r_lat), 64'd5);
        chk(lock_cycles == 2, "R11 lock length mismatch", 64'(lock_cycles), 64'd2);
        do_reset();
        mem[3] = 64'h2019;
        run_op(64'h1018, 1, 1, 0, 0);
        chk(r_flags == 6'h01, "R5 foreign token", 64'(r_flags), 64'h01);
        chk(mem[3] == 64'h2019, "R5 foreign token kept", mem[3], 64'h2019);
    endtask

    task automatic t_pf();
        do_reset();
        mem[1] = 64'h1009;
        pf_on_read = 1; mem_pf_code_i = 16'h0007;
        run_op(64'h1008, 1, 1, 0, 0);
        expect_fault("R9 read page fault", 8'd14, 16'h0007, 0);
        chk(n_writes == 0, "R9 no write after read fault", 64'(n_writes), 64'd0);
        pf_on_read = 0; pf_on_write = 1; mem_pf_code_i = 16'h0003;
        run_op(64'h1008, 1, 1, 0, 0);
        expect_fault("R9 write page fault", 8'd14, 16'h0003, 0);
        chk(mem[1] == 64'h1009, "R9 memory kept", mem[1], 64'h1009);
        pf_on_write = 0;
    endtask

    task automatic t_busy_start();
        int guard;
        do_reset();
        mem[1] = 64'h1009;
        mem[4] = 64'h1021;
        lat = 3;
        n_done = 0; n_writes = 0;
        @(negedge clk);
        op_addr_i = 64'h1008; cet_en_i = 1; sstk_en_i = 1; cpl_i = 0; lock_pfx_i = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        op_addr_i = 64'h1020;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk(n_done == 1, "R10 start while busy ignored", 64'(n_done), 64'd1);
        chk(mem[1] == 64'h1008, "R10 first operation done", mem[1], 64'h1008);
        chk(mem[4] == 64'h1021, "R10 second token untouched", mem[4], 64'h1021);
        lat = 0;
    endtask

    initial begin
        t_reset();
        t_ud();
        t_priv();
        t_align();
        t_valid();
        t_invalid();
        t_pf();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule